// File: doc/BRIEF.md
# Redundant Converter Start-Up Selector

This controller brings one of two redundant power converters onto a medium-voltage bus while the other stays in cold standby, cut off from the bus. Converter A is always tried first. When the bus comparator reports that the input voltage is above the start threshold, the controller sends a close command to the shared bypass switch. After a fixed settling delay it energizes the gate supply of converter A and holds it for a start window. At the end of the window the controller reads the converter's running flag once. If A is running, B's isolation switch is told to open. If A is not running, A is isolated, the bypass command is sent again, and B is started with the same delay and window.

The bypass and isolation switches are latching types, so they get single-cycle command pulses. The gate supply of each converter is a level that stays high for the whole start window. If B also fails to start, the controller isolates B, reports a fault and does nothing more until reset. All comparator and running flags are asynchronous and pass through a synchronizer before the state machine sees them. Each interval is a cycle count built from the clock rate in kHz and a duration in milliseconds.

Top module: `conv_select_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, all command outputs are 0, `sel_o` is 2'b00 and `fault_o` is 0.
- R2: `byp_close_o` pulses for exactly one cycle, SYNC_STAGES+1 clock edges after `over_th_i` is first sampled high in the idle state. While `over_th_i` stays low, no command is issued.
- R3: A gate supply output rises exactly BYP_MS*CLK_KHZ cycles after the `byp_close_o` pulse that precedes it.
- R4: A gate supply output stays high for exactly max(CHK_MS,HOLD_MS)*CLK_KHZ cycles, so it is never held for less than the minimum hold time.
- R5: If converter A's synchronized running flag is high in the last cycle of its window, `iso_b_open_o` pulses once, `sel_o` becomes 2'b01 (bit 0 = A), and this state is kept until reset.
- R6: If A's flag is low at that point, `iso_a_open_o` and `byp_close_o` pulse together in one cycle, and `gate_b_o` rises BYP_MS*CLK_KHZ cycles later.
- R7: If B's flag is high at the end of its window, `sel_o` becomes 2'b10 (bit 1 = B) and no isolation pulse is issued.
- R8: If B's flag is low at the end of its window, `iso_b_open_o` pulses once, `fault_o` goes high with `sel_o` at 2'b00, and this state is kept until reset whatever the inputs do.
- R9: `gate_a_o` and `gate_b_o` are never high together, and `sel_o` never has both bits set.
- R10: A running flag is read only at the end of its converter's window. Toggling it earlier in the window, or toggling `over_th_i` after leaving idle, does not change the outcome.
- R11: Synchronous reset returns the controller to idle from any state, including in the middle of a start window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| over_th_i | input | 1 | Bus above start threshold (asynchronous comparator flag) |
| run_a_i | input | 1 | Converter A reports running (asynchronous) |
| run_b_i | input | 1 | Converter B reports running (asynchronous) |
| byp_close_o | output | 1 | One-cycle close command for the bypass switch |
| gate_a_o | output | 1 | Gate supply switch of converter A closed (level) |
| gate_b_o | output | 1 | Gate supply switch of converter B closed (level) |
| iso_a_open_o | output | 1 | One-cycle open command for A's isolation switch |
| iso_b_open_o | output | 1 | One-cycle open command for B's isolation switch |
| sel_o | output | 2 | Selected converter: bit 0 = A, bit 1 = B, 00 = none |
| fault_o | output | 1 | Both converters failed to start; latched until reset |

## Verification
The assertions assume that reset is asserted from time zero until the first clock edges have passed. They also assume that the running flags are only acted on once they have passed through the synchronizer, so a flag change is seen SYNC_STAGES cycles late. The stimulus changes inputs only between clock edges. It holds each running flag steady for at least SYNC_STAGES+1 cycles before a window ends, so the value the controller samples is always known. The intervals are shortened by giving a small CLK_KHZ, and CHK_MS is set below HOLD_MS so that the window falls back to the minimum hold time.

// File: rtl/conv_sel_pkg.sv
package conv_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BYP   = 3'd1,
    ST_GATE  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } ctl_state_t;

  typedef enum logic {
    CONV_A = 1'b0,
    CONV_B = 1'b1
  } conv_id_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ld_i)        cnt <= ld_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

  // R3
  expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ld_i) |=> done_o);
endmodule

// File: rtl/conv_select_ctrl.sv
module conv_select_ctrl
  import conv_sel_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int BYP_MS      = 15,
  parameter int HOLD_MS     = 4,
  parameter int CHK_MS      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       over_th_i,
  input  logic       run_a_i,
  input  logic       run_b_i,
  output logic       byp_close_o,
  output logic       gate_a_o,
  output logic       gate_b_o,
  output logic       iso_a_open_o,
  output logic       iso_b_open_o,
  output logic [1:0] sel_o,
  output logic       fault_o
);
  localparam int DLY_CYC = CLK_KHZ * BYP_MS;
  localparam int WIN_MS  = (CHK_MS > HOLD_MS) ? CHK_MS : HOLD_MS;
  localparam int WIN_CYC = CLK_KHZ * WIN_MS;
  localparam int MAX_CYC = (DLY_CYC > WIN_CYC) ? DLY_CYC : WIN_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] DLY_LD = TW'(DLY_CYC - 1);
  localparam logic [TW-1:0] WIN_LD = TW'(WIN_CYC - 1);

  logic [2:0] flags_s;
  logic       ot_s, ra_s, rb_s;

  flag_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({run_b_i, run_a_i, over_th_i}),
    .q_o (flags_s)
  );
  assign {rb_s, ra_s, ot_s} = flags_s;

  ctl_state_t    st, nxt_st;
  conv_id_t      cur, nxt_cur;
  logic          t_ld, t_done;
  logic [TW-1:0] t_val;

  step_timer #(.CW(TW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (t_ld),
    .ld_val_i (t_val),
    .done_o   (t_done)
  );

  logic       n_byp, n_ga, n_gb, n_isoa, n_isob, n_fault;
  logic [1:0] n_sel;
  logic       cur_run;

  assign cur_run = (cur == CONV_A) ? ra_s : rb_s;

  always_comb begin
    nxt_st  = st;
    nxt_cur = cur;
    t_ld    = 1'b0;
    t_val   = '0;
    n_byp   = 1'b0;
    n_isoa  = 1'b0;
    n_isob  = 1'b0;
    n_ga    = gate_a_o;
    n_gb    = gate_b_o;
    n_sel   = sel_o;
    n_fault = fault_o;
    unique case (st)
      ST_IDLE: begin
        if (ot_s) begin
          nxt_st  = ST_BYP;
          nxt_cur = CONV_A;
          t_ld    = 1'b1;
          t_val   = DLY_LD;
          n_byp   = 1'b1;
        end
      end
      ST_BYP: begin
        if (t_done) begin
          nxt_st = ST_GATE;
          t_ld   = 1'b1;
          t_val  = WIN_LD;
          n_ga   = (cur == CONV_A);
          n_gb   = (cur == CONV_B);
        end
      end
      ST_GATE: begin
        if (t_done) begin
          n_ga = 1'b0;
          n_gb = 1'b0;
          if (cur_run) begin
            nxt_st = ST_RUN;
            n_sel  = (cur == CONV_A) ? 2'b01 : 2'b10;
            n_isob = (cur == CONV_A);
          end else if (cur == CONV_A) begin
            nxt_st  = ST_BYP;
            nxt_cur = CONV_B;
            t_ld    = 1'b1;
            t_val   = DLY_LD;
            n_isoa  = 1'b1;
            n_byp   = 1'b1;
          end else begin
            nxt_st  = ST_FAULT;
            n_isob  = 1'b1;
            n_fault = 1'b1;
          end
        end
      end
      ST_RUN, ST_FAULT: begin
        nxt_st = st;
      end
      default: begin
        nxt_st = ST_IDLE;
        n_ga   = 1'b0;
        n_gb   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cur          <= CONV_A;
      byp_close_o  <= 1'b0;
      gate_a_o     <= 1'b0;
      gate_b_o     <= 1'b0;
      iso_a_open_o <= 1'b0;
      iso_b_open_o <= 1'b0;
      sel_o        <= 2'b00;
      fault_o      <= 1'b0;
    end else begin
      st           <= nxt_st;
      cur          <= nxt_cur;
      byp_close_o  <= n_byp;
      gate_a_o     <= n_ga;
      gate_b_o     <= n_gb;
      iso_a_open_o <= n_isoa;
      iso_b_open_o <= n_isob;
      sel_o        <= n_sel;
      fault_o      <= n_fault;
    end
  end

  // R9
  gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_a_o && gate_b_o));

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  // R8
  fault_latch_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> (fault_o && sel_o == 2'b00));

  // R6
  failover_pair_chk: assert property (@(posedge clk) disable iff (rst)
    iso_a_open_o |-> byp_close_o);

  // R5
  sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != 2'b00) |=> $stable(sel_o));

  // R4
  gate_a_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_a_o) |-> (iso_a_open_o || iso_b_open_o));

  // R4
  gate_b_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_b_o) |-> (sel_o == 2'b10 || fault_o));

  // R3
  gate_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_a_o) || $rose(gate_b_o)) |-> $past(st) == ST_BYP);
endmodule

// File: tb/conv_select_ctrl_test.sv
module conv_select_ctrl_test;
  localparam int KHZ  = 4;
  localparam int BMS  = 15;
  localparam int HMS  = 4;
  localparam int CMS  = 3;
  localparam int SYN  = 2;
  localparam int DLY  = KHZ * BMS;
  localparam int WIN  = KHZ * ((CMS > HMS) ? CMS : HMS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic over_th = 1'b0, run_a = 1'b0, run_b = 1'b0;
  logic byp, ga, gb, isoa, isob, fault;
  logic [1:0] sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  conv_select_ctrl #(.CLK_KHZ(KHZ), .BYP_MS(BMS), .HOLD_MS(HMS),
                     .CHK_MS(CMS), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst(rst), .over_th_i(over_th), .run_a_i(run_a),
    .run_b_i(run_b), .byp_close_o(byp), .gate_a_o(ga), .gate_b_o(gb),
    .iso_a_open_o(isoa), .iso_b_open_o(isob), .sel_o(sel), .fault_o(fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phases 0 idle, 1 settle, 2 window, 3 running, 4 fault
  int phase = 0, tgt = 0, el = 0;
  int e_byp = 0, e_ga = 0, e_gb = 0, e_isoa = 0, e_isob = 0, e_sel = 0, e_fault = 0;
  int ot_h [$];
  int ra_h [$];
  int rb_h [$];

  initial begin
    for (int i = 0; i < SYN; i++) begin
      ot_h.push_back(0); ra_h.push_back(0); rb_h.push_back(0);
    end
  end

  always @(posedge clk) begin
    int so, sa, sb, runv;
    cyc++;
    if (rst) begin
      phase = 0; tgt = 0; el = 0;
      e_byp = 0; e_ga = 0; e_gb = 0; e_isoa = 0; e_isob = 0; e_sel = 0; e_fault = 0;
      for (int i = 0; i < SYN; i++) begin ot_h[i] = 0; ra_h[i] = 0; rb_h[i] = 0; end
    end else begin
      so = ot_h[SYN-1]; sa = ra_h[SYN-1]; sb = rb_h[SYN-1];
      void'(ot_h.pop_back()); void'(ra_h.pop_back()); void'(rb_h.pop_back());
      ot_h.push_front(int'(over_th)); ra_h.push_front(int'(run_a)); rb_h.push_front(int'(run_b));
      e_byp = 0; e_isoa = 0; e_isob = 0;
      case (phase)
        0: if (so != 0) begin phase = 1; el = 0; tgt = 0; e_byp = 1; end
        1: begin
          el++;
          if (el == DLY) begin
            phase = 2; el = 0;
            if (tgt == 0) e_ga = 1; else e_gb = 1;
          end
        end
        2: begin
          el++;
          if (el == WIN) begin
            e_ga = 0; e_gb = 0;
            runv = (tgt == 0) ? sa : sb;
            if (runv != 0) begin
              phase = 3;
              e_sel = (tgt == 0) ? 1 : 2;
              if (tgt == 0) e_isob = 1;
            end else if (tgt == 0) begin
              phase = 1; el = 0; tgt = 1; e_isoa = 1; e_byp = 1;
            end else begin
              phase = 4; e_isob = 1; e_fault = 1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Per-cycle comparison and interval measurement
  int last_byp = -1000, rise_a = 0, rise_b = 0;
  logic pga = 1'b0, pgb = 1'b0;
  int saw_isoa = 0, saw_isob = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 bypass pulse", int'(byp), e_byp);
      chk("R3 gate A", int'(ga), e_ga);
      chk("R6 gate B", int'(gb), e_gb);
      chk("R6 iso A pulse", int'(isoa), e_isoa);
      chk("R5 iso B pulse", int'(isob), e_isob);
      chk("R7 selection", int'(sel), e_sel);
      chk("R8 fault", int'(fault), e_fault);
      chk("R9 gates exclusive", int'(ga && gb), 0);
      chk("R9 selection onehot0", int'(sel == 2'b11), 0);
      if (byp) last_byp = cyc;
      if (isoa) saw_isoa++;
      if (isob) saw_isob++;
      if (ga && !pga) begin rise_a = cyc; chk("R3 settle delay A", cyc - last_byp, DLY); end
      if (gb && !pgb) begin rise_b = cyc; chk("R3 settle delay B", cyc - last_byp, DLY); end
      if (!ga && pga) chk("R4 window A", cyc - rise_a, WIN);
      if (!gb && pgb) chk("R4 window B", cyc - rise_b, WIN);
    end
    pga = ga; pgb = gb;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    chk(tag, int'({byp, ga, gb, isoa, isob, fault}), 0);
    chk(tag, int'(sel), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; over_th = 1'b0; run_a = 1'b0; run_b = 1'b0;
    step(3);
    rst = 1'b0;
    saw_isoa = 0; saw_isob = 0;
    step(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    // R1: reset state
    step(3);
    idle_check("R1 reset outputs");
    rst = 1'b0;
    step(1);
    idle_check("R1 after release");

    // R2: below threshold nothing happens
    step(40);
    idle_check("R2 no command below threshold");

    // Scenario: A starts
    run_a = 1'b1;
    over_th = 1'b1;
    while (sel == 2'b00) @(negedge clk);
    over_th = 1'b0;   // R10: ignored after idle
    step(30);
    chk("R5 A selected", int'(sel), 1);
    chk("R5 B isolated once", saw_isob, 1);

    // Scenario: A fails despite a glitch early in its window, B starts
    do_reset();
    chk("R11 idle after reset", int'(sel), 0);
    run_b = 1'b1;
    over_th = 1'b1;
    while (!ga) @(negedge clk);
    step(2);  run_a = 1'b1;   // R10 early toggle
    step(4);  run_a = 1'b0;
    while (sel == 2'b00) @(negedge clk);
    step(10);
    chk("R7 B selected", int'(sel), 2);
    chk("R6 A isolated once", saw_isoa, 1);
    chk("R7 no B isolation", saw_isob, 0);
    chk("R10 early toggle ignored", int'(sel), 2);

    // Scenario: both fail
    do_reset();
    over_th = 1'b1;
    while (!fault) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      over_th = ~over_th; run_a = ~run_a; run_b = ~run_b;
      step(5);
    end
    chk("R8 fault latched", int'(fault), 1);
    chk("R8 nothing selected", int'(sel), 0);
    chk("R8 B isolated once", saw_isob, 1);

    // R11: reset in the middle of a window
    do_reset();
    run_a = 1'b1;
    over_th = 1'b1;
    while (!ga) @(negedge clk);
    step(5);
    rst = 1'b1;
    step(2);
    idle_check("R11 reset mid window");
    over_th = 1'b0;
    rst = 1'b0;
    step(20);
    idle_check("R11 idle after mid-window reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule